// File: doc/BRIEF.md
# Infrared Sample Stream Packet Parser

This block sits behind an infrared receiver front end. It takes the receiver's byte stream, one byte at a time through a valid/ready input, and sorts it into two kinds of event. Timing runs are turned into pulse/space events. Each event carries a level flag and a duration in microseconds. Control traffic is turned into command events. Each carries the sub-command code and the payload bytes that followed it.

A small phase machine decides how to read each byte: as a packet header, as a sub-command code, as command payload, or as an IR timing sample. A header whose top three bits are `100` opens a timing run, and its low five bits give the number of samples that follow. Two reserved header values open a command instead. The parser counts down the bytes still owed by the open packet, then falls back to reading headers. Events are registered and appear for exactly one cycle.

Top module: `ir_pkt_parser`

## Requirements
- R1: `rstN` is a synchronous active-low reset. While it is low, `inReady`, `irValid` and `cmdValid` are 0. After reset the parser is in header phase with no bytes owed, and from the first cycle after release `inReady` is 1.
- R2: In header phase the byte 0x00 is consumed with no event, and the next byte is again read as a header.
- R3: In header phase the bytes 0x9f and 0xff open a command, and the next byte is read as a sub-command code. This applies to 0x9f even though its top three bits are `100`.
- R4: Any other header byte whose top three bits are `100` (0x80 to 0x9e) opens a timing run of (byte & 0x1f) samples. 0x80 opens an empty run, and the parser stays in header phase.
- R5: A timing sample produces an event one cycle after it is accepted. `irPulse` is bit 7 of the sample (1 = pulse, 0 = space), and `irDurUs` is the low 7 bits times `SAMPLE_US` (50 by default). Every byte of a run is a sample, including 0x9f and 0x00.
- R6: After the last sample of a run, the next byte is read as a header.
- R7: The payload length follows from the sub-command code: 0x06, 0x0c, 0x0b and 0x15 take 2 bytes; 0x08 and 0x14 take 1 byte; 0x01 and every unknown code take 0 bytes.
- R8: A command event (`cmdValid`) fires one cycle after the last payload byte is accepted, or after the code byte when the length is 0. It carries `cmdCode`, `cmdLen` equal to the payload length, and payload byte i in `cmdPayload[8i+7:8i]`. Unused bytes read 0.
- R9: Any other header byte (top three bits not `100`, and not 0x00 or 0xff) is consumed with no event.
- R10: A cycle without `inValid` accepts nothing. It produces no event and does not advance the phase or the count.
- R11: `irValid` and `cmdValid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| inByte | input | 8 | Received stream byte |
| inValid | input | 1 | `inByte` is offered this cycle |
| inReady | output | 1 | Parser takes a byte this cycle |
| irValid | output | 1 | One-cycle pulse/space event strobe |
| irPulse | output | 1 | 1 = pulse, 0 = space |
| irDurUs | output | 13 | Duration in microseconds |
| cmdValid | output | 1 | One-cycle command event strobe |
| cmdCode | output | 8 | Sub-command code |
| cmdLen | output | 2 | Number of payload bytes |
| cmdPayload | output | 16 | Payload bytes, byte 0 in the low bits |

## Verification
An accepted byte is taken on one rising edge. Any event it causes is visible right after that edge and lasts one cycle, so the latency is exactly one cycle for both `irValid` and `cmdValid`. The bench sets up each byte on a falling edge and holds `inValid` for one cycle. It reads the outputs on the next falling edge, half a cycle after the edge that captured the byte. That point also confirms the quiet outputs for bytes that must produce nothing. Stall gaps with `inValid` low are checked on each falling edge, so any event that appears late or without cause is caught.

// File: rtl/ir_pkt_pkg.sv
package ir_pkt_pkg;

  localparam logic [7:0] HDR_CMD      = 8'h9f;
  localparam logic [7:0] HDR_HW_CMD   = 8'hff;
  localparam logic [7:0] HDR_NULL     = 8'h00;
  localparam logic [2:0] HDR_IR_CLASS = 3'b100;
  localparam int         LEN_FIELD_W  = 5;
  localparam int         SMP_W        = 7;
  localparam int         SMP_MAX      = (1 << SMP_W) - 1;
  localparam int         PLEN_W       = 2;

  localparam logic [7:0] SC_SIG_END   = 8'h01;
  localparam logic [7:0] SC_CARRIER   = 8'h06;
  localparam logic [7:0] SC_TX_MASK   = 8'h08;
  localparam logic [7:0] SC_REVISION  = 8'h0b;
  localparam logic [7:0] SC_TIMEOUT   = 8'h0c;
  localparam logic [7:0] SC_RX_SENSOR = 8'h14;
  localparam logic [7:0] SC_PULSE_CNT = 8'h15;

  typedef enum logic [1:0] {
    PH_HDR  = 2'd0,
    PH_SUB  = 2'd1,
    PH_CDAT = 2'd2,
    PH_IRD  = 2'd3
  } phase_t;

  typedef struct packed {
    logic irEmit;
    logic cmdStart;
    logic payLoad;
    logic cmdEmit;
  } strobe_t;

  function automatic logic [PLEN_W-1:0] payLenOf(input logic [7:0] code);
    logic [PLEN_W-1:0] n;
    case (code)
      SC_CARRIER, SC_TIMEOUT, SC_REVISION, SC_PULSE_CNT: n = PLEN_W'(2);
      SC_TX_MASK, SC_RX_SENSOR:                          n = PLEN_W'(1);
      default:                                           n = '0;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/ir_pkt_ctrl.sv
module ir_pkt_ctrl
  import ir_pkt_pkg::*;
#(
  parameter int CNT_W = LEN_FIELD_W
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] inByte,
  input  logic       inValid,
  output logic       inReady,
  output strobe_t    stb
);

  phase_t             phaseQ, phaseD;
  logic [CNT_W-1:0]   remQ, remD;
  logic               readyQ;
  logic               accept;
  logic [PLEN_W-1:0]  plen;
  logic               isCmdHdr;
  logic               isIrHdr;

  assign inReady  = readyQ;
  assign accept   = inValid && readyQ;
  assign isCmdHdr = (inByte == HDR_CMD) || (inByte == HDR_HW_CMD);
  assign isIrHdr  = (inByte[7:5] == HDR_IR_CLASS) &&
                    (inByte[LEN_FIELD_W-1:0] != '0);
  assign plen     = payLenOf(inByte);

  always_comb begin
    stb    = '0;
    phaseD = phaseQ;
    remD   = remQ;
    if (accept) begin
      unique case (phaseQ)
        PH_HDR: begin
          if (isCmdHdr) begin
            phaseD = PH_SUB;
          end else if (isIrHdr) begin
            phaseD = PH_IRD;
            remD   = CNT_W'(inByte[LEN_FIELD_W-1:0]);
          end
        end
        PH_SUB: begin
          stb.cmdStart = 1'b1;
          if (plen == '0) begin
            stb.cmdEmit = 1'b1;
            phaseD      = PH_HDR;
          end else begin
            remD   = CNT_W'(plen);
            phaseD = PH_CDAT;
          end
        end
        PH_CDAT: begin
          stb.payLoad = 1'b1;
          remD        = remQ - CNT_W'(1);
          if (remQ == CNT_W'(1)) begin
            stb.cmdEmit = 1'b1;
            phaseD      = PH_HDR;
          end
        end
        PH_IRD: begin
          stb.irEmit = 1'b1;
          remD       = remQ - CNT_W'(1);
          if (remQ == CNT_W'(1)) phaseD = PH_HDR;
        end
        default: phaseD = PH_HDR;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_HDR;
      remQ   <= '0;
      readyQ <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      remQ   <= remD;
      readyQ <= 1'b1;
    end
  end

endmodule

// File: rtl/ir_pkt_dp.sv
module ir_pkt_dp
  import ir_pkt_pkg::*;
#(
  parameter int SAMPLE_US = 50,
  parameter int DUR_W     = 13,
  parameter int MAX_PAY   = 2,
  parameter int SLOT_W    = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           inByte,
  input  strobe_t              stb,
  output logic                 irValid,
  output logic                 irPulse,
  output logic [DUR_W-1:0]     irDurUs,
  output logic                 cmdValid,
  output logic [7:0]           cmdCode,
  output logic [SLOT_W-1:0]    cmdLen,
  output logic [MAX_PAY*8-1:0] cmdPayload
);

  logic [DUR_W-1:0]            durD;
  logic                        irValidQ, irPulseQ, cmdValidQ;
  logic [DUR_W-1:0]            durQ;
  logic [7:0]                  codeQ;
  logic [SLOT_W-1:0]           slotQ;
  logic [MAX_PAY-1:0][7:0]     payQ;

  assign durD = DUR_W'(inByte[SMP_W-1:0]) * DUR_W'(SAMPLE_US);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irValidQ  <= 1'b0;
      irPulseQ  <= 1'b0;
      durQ      <= '0;
      cmdValidQ <= 1'b0;
    end else begin
      irValidQ  <= stb.irEmit;
      cmdValidQ <= stb.cmdEmit;
      if (stb.irEmit) begin
        irPulseQ <= inByte[7];
        durQ     <= durD;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeQ <= '0;
      slotQ <= '0;
    end else if (stb.cmdStart) begin
      codeQ <= inByte;
      slotQ <= '0;
    end else if (stb.payLoad && (slotQ < SLOT_W'(MAX_PAY))) begin
      slotQ <= slotQ + SLOT_W'(1);
    end
  end

  for (genvar g = 0; g < MAX_PAY; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN) begin
        payQ[g] <= '0;
      end else if (stb.cmdStart) begin
        payQ[g] <= '0;
      end else if (stb.payLoad && (slotQ == SLOT_W'(g))) begin
        payQ[g] <= inByte;
      end
    end
  end

  assign irValid    = irValidQ;
  assign irPulse    = irPulseQ;
  assign irDurUs    = durQ;
  assign cmdValid   = cmdValidQ;
  assign cmdCode    = codeQ;
  assign cmdLen     = slotQ;
  assign cmdPayload = payQ;

endmodule

// File: rtl/ir_pkt_parser.sv
module ir_pkt_parser
  import ir_pkt_pkg::*;
#(
  parameter int SAMPLE_US = 50,
  parameter int MAX_PAY   = 2,
  localparam int DUR_W    = $clog2(SMP_MAX * SAMPLE_US + 1),
  localparam int SLOT_W   = $clog2(MAX_PAY + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [7:0]           inByte,
  input  logic                 inValid,
  output logic                 inReady,
  output logic                 irValid,
  output logic                 irPulse,
  output logic [DUR_W-1:0]     irDurUs,
  output logic                 cmdValid,
  output logic [7:0]           cmdCode,
  output logic [SLOT_W-1:0]    cmdLen,
  output logic [MAX_PAY*8-1:0] cmdPayload
);

  strobe_t stb;

  ir_pkt_ctrl #(
    .CNT_W (LEN_FIELD_W)
  ) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .inByte  (inByte),
    .inValid (inValid),
    .inReady (inReady),
    .stb     (stb)
  );

  ir_pkt_dp #(
    .SAMPLE_US (SAMPLE_US),
    .DUR_W     (DUR_W),
    .MAX_PAY   (MAX_PAY),
    .SLOT_W    (SLOT_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .inByte     (inByte),
    .stb        (stb),
    .irValid    (irValid),
    .irPulse    (irPulse),
    .irDurUs    (irDurUs),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .cmdLen     (cmdLen),
    .cmdPayload (cmdPayload)
  );

endmodule

// File: rtl/ir_pkt_parser_chk.sv
module ir_pkt_parser_chk
  import ir_pkt_pkg::*;
#(
  parameter int SAMPLE_US = 50,
  parameter int MAX_PAY   = 2,
  localparam int DUR_W    = $clog2(SMP_MAX * SAMPLE_US + 1),
  localparam int SLOT_W   = $clog2(MAX_PAY + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [7:0]           inByte,
  input logic                 inValid,
  input logic                 inReady,
  input logic                 irValid,
  input logic                 irPulse,
  input logic [DUR_W-1:0]     irDurUs,
  input logic                 cmdValid,
  input logic [7:0]           cmdCode,
  input logic [SLOT_W-1:0]    cmdLen,
  input logic [MAX_PAY*8-1:0] cmdPayload
);

  AST_READY_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> inReady); // R1

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> (!irValid && !cmdValid)); // R1

  AST_IR_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    irValid |-> $past(inValid && inReady)); // R5

  AST_IR_FIELDS: assert property (@(posedge clk) disable iff (!rstN)
    irValid |-> (irPulse == $past(inByte[7]) &&
                 irDurUs == DUR_W'($past(inByte[SMP_W-1:0])) * DUR_W'(SAMPLE_US))); // R5

  AST_CMD_LEN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdLen <= SLOT_W'(MAX_PAY))); // R7

  AST_CMD_NEEDS_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $past(inValid && inReady)); // R8

  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !$past(inValid) |-> (!irValid && !cmdValid)); // R10

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    !(irValid && cmdValid)); // R11

endmodule

bind ir_pkt_parser ir_pkt_parser_chk #(
  .SAMPLE_US (SAMPLE_US),
  .MAX_PAY   (MAX_PAY)
) u_chk (.*);

// File: tb/sim_ir_pkt_parser.sv
`timescale 1ns/1ps
module sim_ir_pkt_parser;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  inByte = 8'h00;
  logic        inValid = 1'b0;
  logic        inReady;
  logic        irValid;
  logic        irPulse;
  logic [12:0] irDurUs;
  logic        cmdValid;
  logic [7:0]  cmdCode;
  logic [1:0]  cmdLen;
  logic [15:0] cmdPayload;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ir_pkt_parser u0 (
    .clk        (clk),
    .rstN       (rstN),
    .inByte     (inByte),
    .inValid    (inValid),
    .inReady    (inReady),
    .irValid    (irValid),
    .irPulse    (irPulse),
    .irDurUs    (irDurUs),
    .cmdValid   (cmdValid),
    .cmdCode    (cmdCode),
    .cmdLen     (cmdLen),
    .cmdPayload (cmdPayload)
  );

  // Vector layout: byte[49:42] kind[41:40] (0 none, 1 IR event, 2 command)
  // pulse[39] dur[38:26] code[25:18] len[17:16] payload[15:0]
  localparam int NV = 40;
  localparam logic [49:0] VEC [NV] = '{
    {8'h00, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R2 null ignored
    {8'h83, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R4 run of 3
    {8'h85, 2'd1, 1'b1, 13'd250,  8'h00, 2'd0, 16'h0000}, // R5 pulse
    {8'h0a, 2'd1, 1'b0, 13'd500,  8'h00, 2'd0, 16'h0000}, // R5 space
    {8'hff, 2'd1, 1'b1, 13'd6350, 8'h00, 2'd0, 16'h0000}, // R5 max sample
    {8'h9f, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R6 back to header, R3
    {8'h06, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R7 carrier, 2 bytes
    {8'h12, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000},
    {8'h34, 2'd2, 1'b0, 13'd0,    8'h06, 2'd2, 16'h3412}, // R8
    {8'hff, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R3 hw header
    {8'h08, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R7 tx mask, 1 byte
    {8'h03, 2'd2, 1'b0, 13'd0,    8'h08, 2'd1, 16'h0003}, // R8
    {8'h9f, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000},
    {8'h01, 2'd2, 1'b0, 13'd0,    8'h01, 2'd0, 16'h0000}, // R7 signal end, R8 cleared
    {8'h9f, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000},
    {8'h77, 2'd2, 1'b0, 13'd0,    8'h77, 2'd0, 16'h0000}, // R7 unknown code
    {8'h80, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R4 empty run
    {8'h00, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R2 still header
    {8'h41, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R9 other header
    {8'h81, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R4 run of 1
    {8'h80, 2'd1, 1'b1, 13'd0,    8'h00, 2'd0, 16'h0000}, // R5 zero duration
    {8'h9f, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R6
    {8'h14, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R7 rx sensor
    {8'haa, 2'd2, 1'b0, 13'd0,    8'h14, 2'd1, 16'h00aa}, // R8
    {8'h9f, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000},
    {8'h15, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R7 pulse count
    {8'h01, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000},
    {8'h02, 2'd2, 1'b0, 13'd0,    8'h15, 2'd2, 16'h0201}, // R8
    {8'h9f, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000},
    {8'h0b, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R7 revision
    {8'hcd, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000},
    {8'hef, 2'd2, 1'b0, 13'd0,    8'h0b, 2'd2, 16'hefcd}, // R8
    {8'h9f, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000},
    {8'h0c, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R7 timeout
    {8'h00, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // payload zero is data
    {8'h7f, 2'd2, 1'b0, 13'd0,    8'h0c, 2'd2, 16'h7f00}, // R8
    {8'h82, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R4 run of 2
    {8'h9f, 2'd1, 1'b1, 13'd1550, 8'h00, 2'd0, 16'h0000}, // R5 0x9f as sample
    {8'h00, 2'd1, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}, // R5 0x00 as sample
    {8'h00, 2'd0, 1'b0, 13'd0,    8'h00, 2'd0, 16'h0000}  // R6 header again
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Offer one byte for one cycle; returns at the falling edge after capture.
  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inByte  = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic expectQuiet(input string tag);
    check(!irValid && !cmdValid, tag, {62'd0, irValid, cmdValid}, 64'd0);
  endtask

  task automatic expectIr(input string tag, input logic p, input logic [12:0] d);
    check(irValid && !cmdValid && irPulse == p && irDurUs == d, tag,
          {48'd0, irValid, cmdValid, irPulse, irDurUs},
          {48'd0, 1'b1, 1'b0, p, d});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=<50000", cyc);
      finishRun();
    end
  end

  initial begin
    // R1: state held in reset
    repeat (3) @(negedge clk);
    check(!inReady && !irValid && !cmdValid, "R1 in reset",
          {61'd0, inReady, irValid, cmdValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(inReady == 1'b1, "R1 ready after release", {63'd0, inReady}, 64'd1);
    expectQuiet("R1 quiet after release");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      logic [49:0] v;
      v = VEC[i];
      sendByte(v[49:42]);
      case (v[41:40])
        2'd0: expectQuiet($sformatf("R2 R4 R9 vector %0d", i));
        2'd1: expectIr($sformatf("R5 R6 vector %0d", i), v[39], v[38:26]);
        default:
          check(cmdValid && !irValid && cmdCode == v[25:18] &&
                cmdLen == v[17:16] && cmdPayload == v[15:0],
                $sformatf("R7 R8 vector %0d", i),
                {36'd0, cmdValid, irValid, cmdCode, cmdLen, cmdPayload},
                {36'd0, 1'b1, 1'b0, v[25:18], v[17:16], v[15:0]});
      endcase
    end

    // R10: stall in the middle of a run, byte lines wiggling
    sendByte(8'h82);
    expectQuiet("R4 run open");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      inByte = 8'h9f + 8'(k);
      expectQuiet("R10 stall no event");
    end
    sendByte(8'h05);
    expectIr("R10 run kept count, first sample", 1'b0, 13'd250);
    sendByte(8'h85);
    expectIr("R10 second sample", 1'b1, 13'd250);
    sendByte(8'h9f);
    expectQuiet("R6 header after stalled run");
    sendByte(8'h08);
    sendByte(8'h5a);
    check(cmdValid && cmdCode == 8'h08 && cmdPayload == 16'h005a, "R8 after stall",
          {39'd0, cmdValid, cmdCode, cmdPayload}, {39'd0, 1'b1, 8'h08, 16'h005a});

    // R1: reset in the middle of a run returns to header phase
    sendByte(8'h85);
    sendByte(8'h01);
    expectIr("R5 before reset", 1'b0, 13'd50);
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check(!inReady, "R1 ready low in reset", {63'd0, inReady}, 64'd0);
    @(negedge clk);
    rstN = 1'b1;
    sendByte(8'h01);
    expectQuiet("R1 header phase after reset");
    sendByte(8'h81);
    sendByte(8'h02);
    expectIr("R1 parser usable after reset", 1'b0, 13'd100);

    finishRun();
  end

endmodule